// File: doc/BRIEF.md
# Shadow Scan Snapshot Chain

This block is a row of scan cells. Each cell pairs a functional flip-flop with a separate shadow flip-flop. The functional flip-flops register their data input on every clock edge and nothing else touches them. On a capture event, every shadow flip-flop loads the bit its partner holds, all on the same edge. The shadow chain then moves that snapshot towards its low end, `OUT_W` bits per enabled clock, and presents each word on a registered output with a valid strobe. The functional logic keeps running the whole time.

A capture event is either a manual trigger or a tick of an internal dump timer. The timer fires every `period_i` cycles, counted from the last capture of any kind, and is switched off when `period_i` is zero. If a capture arrives before the current snapshot has been fully emitted, the bits not yet sent are lost and a sticky truncation flag records the event. A counter shows how many bits of the current snapshot have gone out.

Top module: `shadow_snapshot_chain`

## Requirements
- R1: `func_q_o` equals the value `func_d_i` had at the previous clock edge. Capture, shifting, the timer and the flag clear never alter it.
- R2: A capture event is `cap_trig_i` high or a timer tick. It loads all `N_BITS` shadow bits from `func_q_o` as that signal stood before the edge. In the following cycle, `bits_sent_o` is 0.
- R3: A dump is running when a snapshot has been captured and `bits_sent_o` < `N_BITS`. At an edge where `shift_en_i` is high, a dump is running and no capture occurs, one word is shifted out. In the next cycle `dout_vld_o` is 1 and `dout_o` holds snapshot bits [`bits_sent_o` + `OUT_W`-1 : `bits_sent_o`], so the word order is LSB first. In any other case `dout_vld_o` is 0 in the next cycle.
- R4: Each word shifted out adds `OUT_W` to `bits_sent_o`, which stops at `N_BITS`. Once it has stopped, `shift_en_i` produces no valid word. After reset, `bits_sent_o`, `dout_vld_o` and `trunc_o` are 0 and there is no snapshot.
- R5: When a capture and `shift_en_i` fall on the same edge, the capture wins and no word is emitted.
- R6: When `period_i` = P > 0, a timer capture occurs at the P-th edge after the last capture or after reset. A manual capture restarts that count.
- R7: When `period_i` = 0, no timer capture occurs, and only `cap_trig_i` takes snapshots.
- R8: `trunc_o` sets at an edge where a capture occurs while a dump is running. It then stays set until it is cleared.
- R9: `trunc_clr_i` high at an edge clears `trunc_o`. If a truncation occurs at the same edge, setting wins.
- R10: After a truncating capture, the bits of the old snapshot that were not sent are never emitted. The next word is bits [`OUT_W`-1:0] of the new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| func_d_i | input | N_BITS | Next state of the functional flip-flops |
| func_q_o | output | N_BITS | Functional flip-flop outputs |
| cap_trig_i | input | 1 | Manual capture trigger |
| period_i | input | PER_W | Dump period in cycles; 0 disables the timer |
| shift_en_i | input | 1 | Advance the shadow chain by one word |
| trunc_clr_i | input | 1 | Clear the truncation flag |
| dout_o | output | OUT_W | Snapshot word, LSB first |
| dout_vld_o | output | 1 | Marks `dout_o` as valid |
| trunc_o | output | 1 | Sticky flag: a dump was cut short |
| bits_sent_o | output | CNT_W | Bits of the current snapshot already emitted |

## Verification
Every result is due one edge after its cause, with no extra stage. `func_q_o` follows `func_d_i` one edge later. A capture shows up as `bits_sent_o` = 0 after that edge. A shifted word and its strobe appear in the cycle after the edge that moved it. The truncation flag changes at the same edge as the capture that cuts a dump short. The reference model advances once per rising edge, using the inputs held stable since the previous falling edge. All outputs are compared with the model at the next falling edge, so each result is sampled in the cycle it is due. The phases cover continuous and gapped shifting, capture and shift on the same edge, periods shorter and longer than a full dump, a disabled timer, and clear and set on the same edge.

// File: rtl/shs_pkg.sv
package shs_pkg;
  typedef enum logic [1:0] {
    DUMP_EMPTY = 2'd0,
    DUMP_RUN   = 2'd1,
    DUMP_DONE  = 2'd2
  } dump_st_e;

  function automatic int shs_cnt_w(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/shs_cell.sv
module shs_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic cap_i,
  input  logic shift_i,
  input  logic sin_i,
  output logic q_o,
  output logic sq_o
);
  // functional flop: never gated by debug controls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sq_o <= 1'b0;
    else if (cap_i)   sq_o <= q_o;
    else if (shift_i) sq_o <= sin_i;
  end
endmodule

// File: rtl/shs_period_timer.sv
module shs_period_timer #(
  parameter int PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam logic [PER_W-1:0] TMR_MAX = {PER_W{1'b1}};

  logic [PER_W-1:0] tmr_q;
  logic             pv_q;

  assign tick_o = (period_i != '0) &&
                  (({1'b0, tmr_q} + (PER_W+1)'(1)) >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (restart_i)         tmr_q <= '0;
    else if (period_i == '0)    tmr_q <= '0;
    else if (tmr_q != TMR_MAX)  tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  assert_restart_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
    restart_i |=> (tmr_q == '0));

  assert_count_advances_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
    (!restart_i && period_i != '0 && tmr_q != TMR_MAX) |=> (tmr_q == $past(tmr_q) + 1'b1));
endmodule

// File: rtl/shs_dump_ctrl.sv
module shs_dump_ctrl import shs_pkg::*; #(
  parameter int N_BITS = 32,
  parameter int OUT_W  = 4,
  localparam int CNT_W = shs_cnt_w(N_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             shift_req_i,
  input  logic             trunc_clr_i,
  input  logic [OUT_W-1:0] word_i,
  output logic             shift_o,
  output logic [OUT_W-1:0] dout_o,
  output logic             vld_o,
  output logic             trunc_o,
  output logic [CNT_W-1:0] sent_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_BITS);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(OUT_W);

  dump_st_e         st_q;
  logic [CNT_W-1:0] sent_q;
  logic             run;
  logic             pv_q;

  assign run     = (st_q == DUMP_RUN);
  assign shift_o = shift_req_i && run && !cap_i;  // capture wins
  assign sent_o  = sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DUMP_EMPTY;
      sent_q <= '0;
    end else if (cap_i) begin
      st_q   <= DUMP_RUN;
      sent_q <= '0;
    end else if (shift_o) begin
      sent_q <= sent_q + STEP;
      if (sent_q + STEP == FULL) st_q <= DUMP_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      dout_o <= '0;
    end else begin
      vld_o <= shift_o;
      if (shift_o) dout_o <= word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            trunc_o <= 1'b0;
    else if (cap_i && run)  trunc_o <= 1'b1;
    else if (trunc_clr_i)   trunc_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  assert_sent_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= FULL);

  assert_vld_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
    vld_o |-> ($past(shift_req_i) && !$past(cap_i)));

  assert_cap_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (sent_q == '0 && !vld_o));

  assert_trunc_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trunc_o && !trunc_clr_i) |=> trunc_o);

  assert_cut_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && st_q == DUMP_RUN) |=> trunc_o);
endmodule

// File: rtl/shadow_snapshot_chain.sv
module shadow_snapshot_chain import shs_pkg::*; #(
  parameter int N_BITS = 32,
  parameter int OUT_W  = 4,
  parameter int PER_W  = 12,
  localparam int CNT_W = shs_cnt_w(N_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] func_d_i,
  output logic [N_BITS-1:0] func_q_o,
  input  logic              cap_trig_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              shift_en_i,
  input  logic              trunc_clr_i,
  output logic [OUT_W-1:0]  dout_o,
  output logic              dout_vld_o,
  output logic              trunc_o,
  output logic [CNT_W-1:0]  bits_sent_o
);
  logic              tick;
  logic              cap;
  logic              shift;
  logic [N_BITS-1:0] sq;
  logic              pv_q;

  assign cap = cap_trig_i | tick;

  shs_period_timer #(.PER_W(PER_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period_i),
    .restart_i (cap),
    .tick_o    (tick)
  );

  for (genvar i = 0; i < N_BITS; i++) begin : g_cell
    logic sin;
    if (i + OUT_W < N_BITS) begin : g_link
      assign sin = sq[i+OUT_W];
    end else begin : g_tail
      assign sin = 1'b0;
    end
    shs_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .d_i     (func_d_i[i]),
      .cap_i   (cap),
      .shift_i (shift),
      .sin_i   (sin),
      .q_o     (func_q_o[i]),
      .sq_o    (sq[i])
    );
  end

  shs_dump_ctrl #(.N_BITS(N_BITS), .OUT_W(OUT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .shift_req_i (shift_en_i),
    .trunc_clr_i (trunc_clr_i),
    .word_i      (sq[OUT_W-1:0]),
    .shift_o     (shift),
    .dout_o      (dout_o),
    .vld_o       (dout_vld_o),
    .trunc_o     (trunc_o),
    .sent_o      (bits_sent_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  assert_func_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
    func_q_o == $past(func_d_i));

  assert_timer_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
    ($past(period_i) == '0 && !$past(cap_trig_i) && $past(bits_sent_o) == CNT_W'(N_BITS))
      |-> (bits_sent_o == CNT_W'(N_BITS)));
endmodule

// File: tb/shadow_snapshot_chain_tb_top.sv
module shadow_snapshot_chain_tb_top;
  localparam int N  = 32;
  localparam int W  = 4;
  localparam int PW = 12;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  func_d = '0;
  logic [N-1:0]  func_q;
  logic          cap_trig = 1'b0;
  logic [PW-1:0] period = '0;
  logic          shift_en = 1'b0;
  logic          trunc_clr = 1'b0;
  logic [W-1:0]  dout;
  logic          dout_vld;
  logic          trunc;
  logic [CW-1:0] bits_sent;

  always #10 clk = ~clk;

  shadow_snapshot_chain #(.N_BITS(N), .OUT_W(W), .PER_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .func_d_i(func_d), .func_q_o(func_q),
    .cap_trig_i(cap_trig), .period_i(period), .shift_en_i(shift_en),
    .trunc_clr_i(trunc_clr), .dout_o(dout), .dout_vld_o(dout_vld),
    .trunc_o(trunc), .bits_sent_o(bits_sent)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string req = "R4";

  // behavioural reference model
  logic [N-1:0] m_fq = '0, m_snap = '0;
  logic [W-1:0] m_dout = '0;
  int  m_sent = 0, m_tmr = 0;
  bit  m_has = 0, m_trunc = 0, m_vld = 0, m_tick, m_cap, m_act;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_fq = '0; m_snap = '0; m_dout = '0;
      m_sent = 0; m_tmr = 0; m_has = 0; m_trunc = 0; m_vld = 0;
    end else begin
      m_tick = (period != 0) && (m_tmr + 1 >= int'(period));
      m_cap  = cap_trig || m_tick;
      m_act  = m_has && (m_sent < N);
      m_vld  = 0;
      if (m_cap) begin
        if (m_act) m_trunc = 1;
        else if (trunc_clr) m_trunc = 0;
        m_snap = m_fq; m_sent = 0; m_has = 1; m_tmr = 0;
      end else begin
        if (trunc_clr) m_trunc = 0;
        if (period == 0) m_tmr = 0;
        else if (m_tmr < (1 << PW) - 1) m_tmr = m_tmr + 1;
        if (shift_en && m_act) begin
          m_dout = W'(m_snap >> m_sent);
          m_vld = 1;
          m_sent = m_sent + W;
        end
      end
      m_fq = func_d;
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL [%s] %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(func_q == m_fq, "R1 func_q", longint'(func_q), longint'(m_fq));
    chk(dout_vld == m_vld, "R3 dout_vld", longint'(dout_vld), longint'(m_vld));
    if (m_vld) chk(dout == m_dout, "R3 dout", longint'(dout), longint'(m_dout));
    chk(int'(bits_sent) == m_sent, "R4 bits_sent", longint'(bits_sent), longint'(m_sent));
    chk(trunc == m_trunc, "R8 trunc", longint'(trunc), longint'(m_trunc));
  endtask

  task automatic step(bit cap, bit sh, bit clr);
    @(negedge clk);
    cmp_all();
    cap_trig  = cap;
    shift_en  = sh;
    trunc_clr = clr;
    func_d    = N'($urandom);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL [%s] watchdog expired act=0 exp=1", req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R4";
    chk(bits_sent == 0 && !dout_vld && !trunc, "R4 reset state", longint'(bits_sent), 0);
    rst_ni = 1'b1;
    // shift request with no snapshot yet
    for (int i = 0; i < 3; i++) step(0, 1, 0);
    // R2/R3: capture then full continuous dump, then extra shifts (R4)
    req = "R2";
    step(1, 0, 0);
    req = "R3";
    for (int i = 0; i < N / W + 3; i++) step(0, 1, 0);
    req = "R4";
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    // gapped shifting
    req = "R3";
    step(1, 0, 0);
    for (int i = 0; i < 2 * (N / W) + 2; i++) step(0, bit'(i % 2), 0);
    // R5: capture and shift together
    req = "R5";
    step(1, 1, 0);
    step(1, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0);
    // R8/R10: cut a dump short
    req = "R10";
    step(1, 0, 0);
    for (int i = 0; i < N / W + 2; i++) step(0, 1, 0);
    req = "R8";
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    // R9: clear, then clear together with a new truncation
    req = "R9";
    step(0, 0, 1);
    step(1, 0, 0);
    step(0, 1, 0);
    step(1, 0, 1);
    step(0, 0, 0);
    step(0, 0, 1);
    for (int i = 0; i < N / W + 2; i++) step(0, 1, 0);
    // R6: periodic, shorter then longer than a dump, manual restart
    req = "R6";
    period = PW'(5);
    for (int i = 0; i < 30; i++) step(0, 1, 0);
    step(0, 0, 1);
    period = PW'(12);
    for (int i = 0; i < 30; i++) step(0, 1, 0);
    step(1, 1, 0);
    for (int i = 0; i < 20; i++) step(0, bit'(i % 3 != 0), 0);
    period = PW'(1);
    for (int i = 0; i < 6; i++) step(0, 1, 0);
    // R7: timer off
    req = "R7";
    period = '0;
    for (int i = 0; i < 40; i++) step(0, 1, 0);
    @(negedge clk);
    cmp_all();
    chk(int'(bits_sent) == N, "R7 no timer capture", longint'(bits_sent), longint'(N));
    finish_run();
  end
endmodule